// File: doc/BRIEF.md
# Programmable UART Baud Tick Generator

This block produces the 16x oversampling enable pulses that a serial transmitter and receiver use to time their bits. The reference clock is nominally 1.8432 MHz. A 4-bit rate code picks one of fifteen standard bit rates. For each rate the block divides the reference clock by a fixed integer, which is the reference frequency over sixteen times the rate, rounded to the nearest integer. Rate code zero turns the divider off. In that case the transmit tick comes from the rising edges of an external 16x clock, which the block synchronizes into the reference domain.

A separate source bit selects where the receive tick comes from:

- **Source bit 0:** the receive tick follows an external receive clock pin.
- **Source bit 1:** the receive tick follows the transmit tick. The receive-clock pin is then turned around to drive a one-cycle copy of each tick, so that other serial circuits can run from the same rate.

All outputs are single-cycle enables in the reference domain, not derived clocks. A new rate code takes effect only at the end of the period that is running when it is written. This keeps tick spacing free of runt intervals.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and after reset is released, the rate code is 0 and the receive source bit is 0. rxClkOe and rxClkOut are low. No txTick occurs while extTxClk stays idle.
- R2: For a nonzero rate code in cfgRate, txTick pulses once every D reference cycles. The codes 1 to 15 give D = 2304, 1536, 1048, 856, 768, 384, 192, 96, 64, 48, 32, 24, 16, 12 and 6 in that order (50, 75, 109.92, 134.58, 150, 300, 600, 1200, 1800, 2400, 3600, 4800, 7200, 9600 and 19200 baud at 16x).
- R3: A write that moves the rate code from 0 to a nonzero value with divisor D produces the first txTick D clock edges after the write edge.
- R4: A rate code written in the middle of a period does not shorten or stretch that period. The following period uses the new divisor.
- R5: With rate code 0, txTick pulses once for each rising edge of extTxClk, visible after the second clock edge following that edge. A falling edge gives no pulse.
- R6: With the source bit (cfgRxInt) at 0, rxTick pulses once for each rising edge of rxClkIn, with the same two-edge latency. rxClkOe and rxClkOut stay low.
- R7: With the source bit at 1, rxTick equals txTick in every cycle, rxClkIn has no effect, and rxClkOe is high. rxClkOe rises only as the result of a configuration write.
- R8: While rxClkOe is high, rxClkOut is high for exactly the cycle after each txTick.
- R9: txTick and rxTick never stay high for two consecutive cycles.
- R10: Asserting reset during operation returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 1.8432 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Loads cfgRate and cfgRxInt on this clock edge |
| cfgRate | input | 4 | Rate code: 0 selects the external clock, 1 to 15 select the internal rates |
| cfgRxInt | input | 1 | Receive tick source: 0 selects the pin, 1 selects the internal source |
| extTxClk | input | 1 | External 16x transmit clock (asynchronous) |
| rxClkIn | input | 1 | Input side of the receive-clock pin |
| rxClkOut | output | 1 | Output side of the receive-clock pin |
| rxClkOe | output | 1 | Drive enable for the receive-clock pin |
| txTick | output | 1 | 16x transmit enable pulse |
| rxTick | output | 1 | 16x receive enable pulse |

## Verification
The assertions assume that each phase of extTxClk and rxClkIn lasts longer than one reference cycle, so that every rising edge shows up through the synchronizer as exactly one pulse. They also assume that configuration writes are synchronous to clk. The bench drives both external clocks with phases of at least three reference cycles and changes them only at the falling edge of clk. It presents all configuration through single-cycle writes, so every rate change and source change lands at a known edge from which the tick spacing is counted.

// File: rtl/baud_tick_gen_pkg.sv
package baud_tick_gen_pkg;

  localparam int unsigned CODE_W = 4;

  // Control strobes from the control block to the divider datapath.
  typedef struct packed {
    logic              run;   // divider active (nonzero rate code)
    logic [CODE_W-1:0] code;  // rate selection
  } divCtl_t;

  // Bit rate times 100 for each rate code; 0 means no internal rate.
  function automatic int unsigned centiBaud(input logic [CODE_W-1:0] code);
    case (code)
      4'd1:    return 5000;
      4'd2:    return 7500;
      4'd3:    return 10992;
      4'd4:    return 13458;
      4'd5:    return 15000;
      4'd6:    return 30000;
      4'd7:    return 60000;
      4'd8:    return 120000;
      4'd9:    return 180000;
      4'd10:   return 240000;
      4'd11:   return 360000;
      4'd12:   return 480000;
      4'd13:   return 720000;
      4'd14:   return 960000;
      4'd15:   return 1920000;
      default: return 0;
    endcase
  endfunction

  // Reference cycles per 16x tick, rounded to nearest.
  function automatic int unsigned divisorFor(input int unsigned refHz,
                                             input int unsigned overSample,
                                             input logic [CODE_W-1:0] code);
    longint num;
    longint den;
    if (centiBaud(code) == 0) return 0;
    num = longint'(refHz) * 100;
    den = longint'(overSample) * longint'(centiBaud(code));
    return 32'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/baud_tick_edge_sync.sv
module baud_tick_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  // sync chain plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/baud_tick_divider.sv
module baud_tick_divider
  import baud_tick_gen_pkg::*;
#(
  parameter int unsigned REF_HZ     = 1843200,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    intTick
);
  localparam int unsigned NUM_CODES = 1 << CODE_W;
  localparam int unsigned MAX_DIV   = divisorFor(REF_HZ, OVERSAMPLE, 4'd1);
  localparam int unsigned CNT_W     = $clog2(MAX_DIV);

  logic [CNT_W-1:0] reloadTab [NUM_CODES];

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tab
    localparam int unsigned DIV_I = divisorFor(REF_HZ, OVERSAMPLE, CODE_W'(i));
    if (DIV_I == 0) begin : g_off
      assign reloadTab[i] = '0;
    end else begin : g_on
      assign reloadTab[i] = CNT_W'(DIV_I - 1);
    end
  end

  logic             parked;
  logic [CNT_W-1:0] count;

  // Counter reloads only when parked or at terminal count, so a new
  // code never truncates the running period.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parked <= 1'b1;
      count  <= '0;
    end else if (!ctl.run) begin
      parked <= 1'b1;
      count  <= '0;
    end else if (parked || count == '0) begin
      parked <= 1'b0;
      count  <= reloadTab[ctl.code];
    end else begin
      count  <= count - 1'b1;
    end
  end

  assign intTick = !parked && (count == '0);
endmodule

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_gen_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CODE_W-1:0] cfgRate,
  input  logic              cfgRxInt,
  input  logic              extTxClk,
  input  logic              rxClkIn,
  input  logic              intTick,
  output divCtl_t           ctl,
  output logic              txTick,
  output logic              rxTick,
  output logic              rxClkOut,
  output logic              rxClkOe
);
  logic [CODE_W-1:0] rateCode;
  logic              rxSrcInt;
  logic              extTxRise;
  logic              rxPinRise;
  logic              rxPulseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCode <= '0;
      rxSrcInt <= 1'b0;
    end else if (cfgWe) begin
      rateCode <= cfgRate;
      rxSrcInt <= cfgRxInt;
    end
  end

  baud_tick_edge_sync #(.STAGES(SYNC_STAGES)) u_txSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (extTxClk),
    .rise (extTxRise)
  );

  baud_tick_edge_sync #(.STAGES(SYNC_STAGES)) u_rxSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rxClkIn),
    .rise (rxPinRise)
  );

  always_comb begin
    ctl.run  = (rateCode != '0);
    ctl.code = rateCode;
  end

  assign txTick = ctl.run ? intTick : extTxRise;
  assign rxTick = rxSrcInt ? txTick : rxPinRise;

  always_ff @(posedge clk) begin
    if (!rstN) rxPulseQ <= 1'b0;
    else       rxPulseQ <= txTick & rxSrcInt;
  end

  assign rxClkOe  = rxSrcInt;
  assign rxClkOut = rxPulseQ & rxSrcInt;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_gen_pkg::*;
#(
  parameter int unsigned REF_HZ      = 1843200,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [3:0] cfgRate,
  input  logic       cfgRxInt,
  input  logic       extTxClk,
  input  logic       rxClkIn,
  output logic       rxClkOut,
  output logic       rxClkOe,
  output logic       txTick,
  output logic       rxTick
);
  divCtl_t           divCtl;
  logic              intTick;
  logic [CODE_W-1:0] rateCode;

  assign rateCode = divCtl.code;

  baud_tick_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgRate  (cfgRate),
    .cfgRxInt (cfgRxInt),
    .extTxClk (extTxClk),
    .rxClkIn  (rxClkIn),
    .intTick  (intTick),
    .ctl      (divCtl),
    .txTick   (txTick),
    .rxTick   (rxTick),
    .rxClkOut (rxClkOut),
    .rxClkOe  (rxClkOe)
  );

  baud_tick_divider #(.REF_HZ(REF_HZ), .OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (divCtl),
    .intTick (intTick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_tick_gen_pkg::*;
#(
  parameter int unsigned REF_HZ     = 1843200,
  parameter int unsigned OVERSAMPLE = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic       txTick,
  input logic       rxTick,
  input logic       rxClkOut,
  input logic       rxClkOe,
  input logic [3:0] rateCode
);
  localparam int unsigned MAX_DIV = divisorFor(REF_HZ, OVERSAMPLE, 4'd1);

  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN || rateCode == '0 || txTick) gap <= '0;
    else                                   gap <= gap + 1'b1;
  end

  // R9
  tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick |=> !txTick);

  // R9
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |=> !rxTick);

  // R7
  rx_follows_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxClkOe |-> (rxTick == txTick));

  // R7
  oe_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxClkOe) |-> $past(cfgWe));

  // R8
  pin_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxClkOe && $past(rxClkOe)) |-> (rxClkOut == $past(txTick)));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode != '0) |-> (gap < MAX_DIV));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.REF_HZ(REF_HZ), .OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .txTick   (txTick),
  .rxTick   (rxTick),
  .rxClkOut (rxClkOut),
  .rxClkOe  (rxClkOe),
  .rateCode (rateCode)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgRate = 4'd0;
  logic       cfgRxInt = 1'b0;
  logic       extTxClk = 1'b0;
  logic       rxClkIn = 1'b0;
  logic       rxClkOut, rxClkOe, txTick, rxTick;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRate(cfgRate),
    .cfgRxInt(cfgRxInt), .extTxClk(extTxClk), .rxClkIn(rxClkIn),
    .rxClkOut(rxClkOut), .rxClkOe(rxClkOe), .txTick(txTick), .rxTick(rxTick)
  );

  function automatic int expDiv(input int code);
    case (code)
      1: return 2304;  2: return 1536;  3: return 1048;  4: return 856;
      5: return 768;   6: return 384;   7: return 192;   8: return 96;
      9: return 64;    10: return 48;   11: return 32;   12: return 24;
      13: return 16;   14: return 12;   15: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [3:0] rc, input logic rxi);
    @(negedge clk);
    cfgWe = 1'b1; cfgRate = rc; cfgRxInt = rxi;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitTxTick();
    int n = 0;
    while (!txTick && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic txGap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!txTick && g < 6000);
  endtask

  task automatic testReset();
    int ticks = 0;
    repeat (4) @(negedge clk);
    check(!rxClkOe && !rxClkOut, "R1", "pin during reset", rxClkOe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(txTick == 0, "R1", "txTick after reset", txTick, 0);
    check(rxTick == 0, "R1", "rxTick after reset", rxTick, 0);
    check(rxClkOe == 0, "R1", "rxClkOe after reset", rxClkOe, 0);
    check(rxClkOut == 0, "R1", "rxClkOut after reset", rxClkOut, 0);
    for (int i = 0; i < 3000; i++) begin @(negedge clk); ticks += txTick; end
    check(ticks == 0, "R1", "idle tick count", ticks, 0);
  endtask

  task automatic testEnable();
    int n = 0;
    writeCfg(4'd15, 1'b0);
    while (!txTick && n < 100) begin @(negedge clk); n++; end
    check(n == 6, "R3", "first tick edges after write", n, 6);
  endtask

  task automatic testPeriods();
    int codes[7] = '{15, 14, 13, 8, 4, 3, 1};
    foreach (codes[k]) begin
      int g;
      writeCfg(4'(codes[k]), 1'b0);
      waitTxTick();
      txGap(g);
      check(g == expDiv(codes[k]), "R2", $sformatf("period code %0d", codes[k]), g, expDiv(codes[k]));
      txGap(g);
      check(g == expDiv(codes[k]), "R2", $sformatf("repeat code %0d", codes[k]), g, expDiv(codes[k]));
    end
  endtask

  task automatic testChange();
    int n = 0;
    int g;
    writeCfg(4'd15, 1'b0);
    waitTxTick();
    txGap(g);
    do begin
      @(negedge clk); n++;
      if (n == 1) begin cfgWe = 1'b1; cfgRate = 4'd14; cfgRxInt = 1'b0; end
      else if (n == 2) cfgWe = 1'b0;
    end while (!txTick && n < 100);
    check(n == 6, "R4", "period spanning change", n, 6);
    txGap(g);
    check(g == 12, "R4", "period after change", g, 12);
  endtask

  task automatic testExtTx();
    int ticks = 0;
    int prev = 0;
    int dbl = 0;
    writeCfg(4'd0, 1'b0);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 20; i++) begin @(negedge clk); ticks += txTick; end
    check(ticks == 0, "R5", "no tick without ext edge", ticks, 0);
    extTxClk = 1'b1;
    @(negedge clk); check(txTick == 0, "R5", "tick after one edge", txTick, 0);
    @(negedge clk); check(txTick == 1, "R5", "tick after two edges", txTick, 1);
    @(negedge clk); check(txTick == 0, "R5", "tick after three edges", txTick, 0);
    repeat (3) @(negedge clk);
    extTxClk = 1'b0;
    ticks = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); ticks += txTick; end
    check(ticks == 0, "R5", "falling edge ignored", ticks, 0);
    ticks = 0;
    for (int i = 0; i < 84; i++) begin
      if (i % 4 == 0 && i < 80) extTxClk = ~extTxClk;
      @(negedge clk);
      ticks += txTick;
      if (prev && txTick) dbl++;
      prev = txTick;
    end
    check(ticks == 10, "R5", "ext rise count", ticks, 10);
    check(dbl == 0, "R9", "consecutive tx ticks (ext)", dbl, 0);
  endtask

  task automatic testRxExt();
    int rises = 0;
    int ticks = 0;
    int pinBad = 0;
    writeCfg(4'd13, 1'b0);
    rxClkIn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 205; i++) begin
      if (i % 5 == 0 && i < 200) begin
        rxClkIn = ~rxClkIn;
        if (rxClkIn) rises++;
      end
      @(negedge clk);
      ticks += rxTick;
      if (rxClkOe || rxClkOut) pinBad++;
    end
    check(ticks == rises, "R6", "rx ticks from pin", ticks, rises);
    check(pinBad == 0, "R6", "pin driven while external", pinBad, 0);
    repeat (3) @(negedge clk);
    rxClkIn = 1'b1;
    @(negedge clk); check(rxTick == 0, "R6", "rx tick after one edge", rxTick, 0);
    @(negedge clk); check(rxTick == 1, "R6", "rx tick after two edges", rxTick, 1);
    rxClkIn = 1'b0;
  endtask

  task automatic testRxInt();
    int follow = 0;
    int echo = 0;
    int oeBad = 0;
    int ticks = 0;
    int dbl = 0;
    logic prevTx;
    writeCfg(4'd13, 1'b1);
    prevTx = txTick;
    for (int i = 0; i < 160; i++) begin
      if (i % 3 == 0) rxClkIn = ~rxClkIn;
      @(negedge clk);
      if (rxTick != txTick) follow++;
      if (rxClkOut != prevTx) echo++;
      if (!rxClkOe) oeBad++;
      if (prevTx && txTick) dbl++;
      ticks += txTick;
      prevTx = txTick;
    end
    check(follow == 0, "R7", "rxTick differs from txTick", follow, 0);
    check(oeBad == 0, "R7", "rxClkOe low while internal", oeBad, 0);
    check(ticks == 10, "R7", "tx ticks in window", ticks, 10);
    check(echo == 0, "R8", "pin echo mismatches", echo, 0);
    check(dbl == 0, "R9", "consecutive ticks (internal)", dbl, 0);
    rxClkIn = 1'b0;
  endtask

  task automatic testResetMid();
    int ticks = 0;
    writeCfg(4'd15, 1'b1);
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rxClkOe == 0, "R10", "rxClkOe after mid reset", rxClkOe, 0);
    check(rxClkOut == 0, "R10", "rxClkOut after mid reset", rxClkOut, 0);
    for (int i = 0; i < 100; i++) begin @(negedge clk); ticks += txTick; end
    check(ticks == 0, "R10", "ticks after mid reset", ticks, 0);
  endtask

  initial begin
    testReset();
    testEnable();
    testPeriods();
    testChange();
    testExtTx();
    testRxExt();
    testRxInt();
    testResetMid();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule